// File: doc/BRIEF.md
# Cascadable Shift-Register Magnitude Comparator

This block is one byte-wide slice that keeps a stored word in a register and constantly weighs it against the value on a data bus. The register can take the whole bus word in one clock, shift one place per clock through a serial chain, drive the bus back from its contents, or hold. Whatever the register is doing, the slice reports whether the stored word is greater than, less than or equal to the bus. A mode input switches between an unsigned compare and a two's-complement compare.

The three status results are modelled as open-collector lines. Each slice outputs a pull-down enable per line, and the board-level line is the wired-AND of all slices: a line reads high when no slice pulls it. A true condition leaves its own line released and pulls the other two low. A high status-off input releases all three. Slices are chained for longer words. The cascade output of each more significant slice drives the cascade input of the next lower slice and the status-off input of the slice itself. The top slice gets a constant high cascade input, and the bottom slice has status-off tied low. Only the top slice gets the signed mode. Priority then falls to the highest byte that differs. The same cascade pins carry serial data when the slices shift.

The register update follows a four-state operation code taken from the select inputs. The states are HOLD (00), READ (01), SHIFT (10) and LOAD (11). Every state can follow every other on any clock. HOLD and READ keep the register. SHIFT moves it one place toward the most significant bit. LOAD copies the bus into it. The compare outcome is a three-state relation: LT, EQ or GT. It follows the register and the bus combinationally.

Top module: `shift_cmp_slice`

## Requirements
- R1: An active-low reset clears the register to zero, so after reset a zero bus compares equal.
- R2: bus_oe is high only while sel is 01 (READ), and bus_out then equals the register; with any other select bus_oe is low.
- R3: With sel 11 (LOAD) the register takes bus_in on the rising clock edge.
- R4: With sel 10 (SHIFT) the register becomes {register[6:0], cas_si} on the rising edge, and cas_so shows register bit 7 while shifting.
- R5: With sel 00 (HOLD) or 01 (READ) the register keeps its value whatever the bus carries.
- R6: With mode_signed low, cas_si high and stat_off low, exactly two pull-down enables are high: the one for the true relation (register vs bus, unsigned) is low.
- R7: With mode_signed high, the register and the bus are compared as two's-complement numbers (bit 7 is the sign).
- R8: With stat_off high, gt_dn, lt_dn and eq_dn are all low.
- R9: With cas_si low, gt_dn and lt_dn are low, while eq_dn still reflects inequality when stat_off is low.
- R10: With any select other than 10, cas_so equals cas_si AND (register equals bus).
- R11: Three slices in a cascade produce wired-AND GT/LT/EQ lines that match a 24-bit compare of the stored word with the bus word. This compare is signed when the top slice has mode_signed high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register updates occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register |
| sel | input | 2 | Operation: 00 HOLD, 01 READ, 10 SHIFT, 11 LOAD |
| cas_si | input | 1 | Serial data in during SHIFT; cascade enable otherwise |
| stat_off | input | 1 | High releases all three status lines |
| mode_signed | input | 1 | High selects a two's-complement compare |
| bus_in | input | 8 | Value seen on the data bus |
| bus_out | output | 8 | Register value driven toward the bus (zero when not driving) |
| bus_oe | output | 1 | Bus driver enable, high in READ only |
| cas_so | output | 1 | Serial data out during SHIFT; cascade equality out otherwise |
| gt_dn | output | 1 | Pull-down enable for the greater-than line |
| lt_dn | output | 1 | Pull-down enable for the less-than line |
| eq_dn | output | 1 | Pull-down enable for the equal line |

## Verification
The compare is swept over a three-slice cascade. Byte values are chosen around the sign boundary (00, 01, 7F, 80, 81, FF and two interior codes). Four word shapes are built from them. Words that differ in the top byte show that the top slice takes priority. Words equal everywhere except the bottom byte force priority to pass down the whole chain. Words that differ only in the middle byte test a partial hand-down, and fully independent words mix all three cases. Each pair is run unsigned and signed. Pairs whose sign bits differ therefore give opposite answers in the two modes, which separates R7 from R6. Separate patterns cover the rest. A low cascade input with unequal and with equal words isolates the gating. An equal top byte shows its lines released. A serial bit stream shifted across all three slices exposes the order of the bits.

// File: rtl/shift_cmp_pkg.sv
package shift_cmp_pkg;

    // Register operation, decoded straight from the select pins
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_READ  = 2'b01,
        OP_SHIFT = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

    // Relation of the stored word to the bus word
    typedef enum logic [1:0] {
        REL_LT = 2'b00,
        REL_EQ = 2'b01,
        REL_GT = 2'b10
    } rel_e;

endpackage

// File: rtl/shift_cmp_store.sv
module shift_cmp_store
    import shift_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    localparam int LOW_BITS = WIDTH - 1;

    logic [WIDTH-1:0] q_next;

    // Next-state selection per operation state
    always_comb begin
        unique case (op)
            OP_HOLD:  q_next = q;
            OP_READ:  q_next = q;
            OP_SHIFT: q_next = {q[LOW_BITS-1:0], ser_in};
            OP_LOAD:  q_next = par_in;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    // R3: a load captures the bus
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (q == $past(par_in)));

    // R4: a shift moves one place up and takes the serial bit at bit 0
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (q == {$past(q[LOW_BITS-1:0]), $past(ser_in)}));

    // R5: hold and read keep the contents
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_HOLD) || (op == OP_READ)) |=> $stable(q));

endmodule

// File: rtl/shift_cmp_magnitude.sv
module shift_cmp_magnitude
    import shift_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] reg_val,
    input  logic [WIDTH-1:0] bus_val,
    input  logic             signed_mode,
    output rel_e             rel
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] reg_key;
    logic [WIDTH-1:0] bus_key;

    // Inverting the sign bit maps two's complement onto unsigned order
    always_comb begin
        reg_key      = reg_val;
        bus_key      = bus_val;
        reg_key[TOP] = reg_val[TOP] ^ signed_mode;
        bus_key[TOP] = bus_val[TOP] ^ signed_mode;
        if (reg_key == bus_key) begin
            rel = REL_EQ;
        end else if (reg_key > bus_key) begin
            rel = REL_GT;
        end else begin
            rel = REL_LT;
        end
    end

endmodule

// File: rtl/shift_cmp_status.sv
module shift_cmp_status
    import shift_cmp_pkg::*;
(
    input  rel_e rel,
    input  logic cas_in,
    input  logic stat_off,
    input  logic shifting,
    input  logic msb,
    output logic gt_dn,
    output logic lt_dn,
    output logic eq_dn,
    output logic cas_out
);

    logic gt_hit;
    logic lt_hit;
    logic eq_hit;

    always_comb begin
        gt_hit = 1'b0;
        lt_hit = 1'b0;
        eq_hit = 1'b0;
        unique case (rel)
            REL_GT:  gt_hit = 1'b1;
            REL_LT:  lt_hit = 1'b1;
            REL_EQ:  eq_hit = 1'b1;
            default: eq_hit = 1'b0;
        endcase
    end

    // Active-off lines: a false condition pulls low; cascade input gates GT/LT
    always_comb begin
        gt_dn   = !stat_off && cas_in && !gt_hit;
        lt_dn   = !stat_off && cas_in && !lt_hit;
        eq_dn   = !stat_off && !eq_hit;
        cas_out = shifting ? msb : (cas_in && eq_hit);
    end

endmodule

// File: rtl/shift_cmp_slice.sv
module shift_cmp_slice
    import shift_cmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             cas_si,
    input  logic             stat_off,
    input  logic             mode_signed,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             cas_so,
    output logic             gt_dn,
    output logic             lt_dn,
    output logic             eq_dn
);

    localparam int TOP = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] q_reg;
    rel_e             rel;

    assign op = op_e'(sel);

    shift_cmp_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ser_in (cas_si),
        .par_in (bus_in),
        .q      (q_reg)
    );

    shift_cmp_magnitude #(.WIDTH(WIDTH)) u_mag (
        .reg_val     (q_reg),
        .bus_val     (bus_in),
        .signed_mode (mode_signed),
        .rel         (rel)
    );

    shift_cmp_status u_status (
        .rel      (rel),
        .cas_in   (cas_si),
        .stat_off (stat_off),
        .shifting (op == OP_SHIFT),
        .msb      (q_reg[TOP]),
        .gt_dn    (gt_dn),
        .lt_dn    (lt_dn),
        .eq_dn    (eq_dn),
        .cas_out  (cas_so)
    );

    // Bus drivers are on in READ only
    always_comb begin
        bus_oe  = (op == OP_READ);
        bus_out = bus_oe ? q_reg : '0;
    end

    // R2: a driven bus carries the stored word
    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_out == q_reg));

    // R6: an enabled slice pulls exactly two lines
    p_two_pulled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_off && cas_si) |-> ($countones({gt_dn, lt_dn, eq_dn}) == 2));

    // R7: with differing signs the negative operand is the smaller one
    p_sign_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_signed && !stat_off && cas_si && (q_reg[TOP] != bus_in[TOP]))
            |-> (gt_dn == q_reg[TOP]));

    // R8: status-off releases every line
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_off |-> (!gt_dn && !lt_dn && !eq_dn));

    // R9: a low cascade input silences GT and LT
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_si |-> (!gt_dn && !lt_dn));

    // R10: outside SHIFT the cascade output reports gated equality
    p_cso_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_SHIFT) |-> (cas_so == (cas_si && (q_reg == bus_in))));

endmodule

// File: tb/test_shift_cmp_slice.sv
module test_shift_cmp_slice;
    import shift_cmp_pkg::*;

    localparam int WIDTH  = 8;
    localparam int SLICES = 3;
    localparam int TOTAL  = WIDTH * SLICES;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic             rst_n;
    logic [1:0]       sel;
    logic             top_si;
    logic             mode_top;
    logic [TOTAL-1:0] bus_w;
    logic [TOTAL-1:0] rd_w;
    logic [SLICES-1:0] oe_w, cso_w, gtd, ltd, eqd;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        logic si_k, off_k, md_k;
        if (k == SLICES - 1) begin : g_top
            assign si_k = top_si;
            assign md_k = mode_top;
        end else begin : g_low
            assign si_k = cso_w[k+1];
            assign md_k = 1'b0;
        end
        if (k == 0) begin : g_lsb
            assign off_k = 1'b0;
        end else begin : g_up
            assign off_k = cso_w[k];
        end
        shift_cmp_slice #(.WIDTH(WIDTH)) i_shift_cmp_slice (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel         (sel),
            .cas_si      (si_k),
            .stat_off    (off_k),
            .mode_signed (md_k),
            .bus_in      (bus_w[k*WIDTH +: WIDTH]),
            .bus_out     (rd_w[k*WIDTH +: WIDTH]),
            .bus_oe      (oe_w[k]),
            .cas_so      (cso_w[k]),
            .gt_dn       (gtd[k]),
            .lt_dn       (ltd[k]),
            .eq_dn       (eqd[k])
        );
    end

    // Wired-AND resolution of the shared lines
    logic gt_line, lt_line, eq_line;
    assign gt_line = ~|gtd;
    assign lt_line = ~|ltd;
    assign eq_line = ~|eqd;

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pick(input int i);
        case (i % 8)
            0: pick = 8'h00;
            1: pick = 8'h01;
            2: pick = 8'h3C;
            3: pick = 8'h7F;
            4: pick = 8'h80;
            5: pick = 8'h81;
            6: pick = 8'hC3;
            default: pick = 8'hFF;
        endcase
    endfunction

    // Expected {gt, lt, eq} line levels
    function automatic logic [2:0] ref_lines(input logic [TOTAL-1:0] a, input logic [TOTAL-1:0] b,
                                             input logic sgn);
        logic gt, lt;
        if (sgn) begin
            gt = $signed(a) > $signed(b);
            lt = $signed(a) < $signed(b);
        end else begin
            gt = a > b;
            lt = a < b;
        end
        ref_lines = {gt, lt, (a == b)};
    endfunction

    task automatic load_word(input logic [TOTAL-1:0] v);
        @(negedge clk);
        sel   = 2'b11;
        bus_w = v;
        @(negedge clk);
        sel   = 2'b00;
    endtask

    task automatic read_check(input string tag, input logic [TOTAL-1:0] exp);
        @(negedge clk);
        sel = 2'b01;
        #1;
        chk(tag, rd_w, exp);
        @(negedge clk);
        sel = 2'b00;
    endtask

    task automatic cmp_check(input logic [TOTAL-1:0] a, input logic [TOTAL-1:0] b, input logic sgn);
        load_word(a);
        bus_w    = b;
        mode_top = sgn;
        #1;
        chk(sgn ? "R11/R7 signed cascade lines" : "R11/R6 unsigned cascade lines",
            {gt_line, lt_line, eq_line}, ref_lines(a, b, sgn));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] e [SLICES];
        logic [9:0] stream;
        logic [TOTAL-1:0] a, b;

        rst_n    = 1'b0;
        sel      = 2'b00;
        top_si   = 1'b1;
        mode_top = 1'b0;
        bus_w    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared register equals a zero bus
        #1;
        chk("R1 reset equal line", {gt_line, lt_line, eq_line}, 3'b001);
        chk("R2 no drive in HOLD", oe_w, 3'b000);
        @(negedge clk);
        sel = 2'b01;
        #1;
        chk("R1 reset contents", rd_w, '0);
        chk("R2 drive in READ", oe_w, 3'b111);
        @(negedge clk);
        sel = 2'b10;
        #1;
        chk("R2 no drive in SHIFT", oe_w, 3'b000);
        sel = 2'b11;
        #1;
        chk("R2 no drive in LOAD", oe_w, 3'b000);
        @(negedge clk);
        sel = 2'b00;

        // R3 load and R5 hold against a changing bus
        load_word(24'hA5_3C_81);
        read_check("R3 loaded word", 24'hA5_3C_81);
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            bus_w = 24'h5A_C3_7E ^ TOTAL'(n);
        end
        read_check("R5 held word", 24'hA5_3C_81);

        // R4: serial stream across the chain
        load_word(24'h81_40_01);
        e[2] = 8'h81; e[1] = 8'h40; e[0] = 8'h01;
        stream = 10'b1101001110;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            sel    = 2'b10;
            top_si = stream[n];
            #1;
            chk("R4 serial out of top slice", cso_w[2], e[2][7]);
            e[0] = {e[0][6:0], e[1][7]};
            e[1] = {e[1][6:0], e[2][7]};
            e[2] = {e[2][6:0], stream[n]};
        end
        @(negedge clk);
        sel    = 2'b00;
        top_si = 1'b1;
        read_check("R4 shifted word", {e[2], e[1], e[0]});

        // R8 and R10: equal top byte hands down priority
        load_word(24'h42_10_99);
        bus_w = 24'h42_20_99;
        #1;
        chk("R10 cascade out on equal byte", cso_w[2], 1'b1);
        chk("R8 top slice released", {gtd[2], ltd[2], eqd[2]}, 3'b000);
        chk("R11 middle decides", {gt_line, lt_line, eq_line}, 3'b010);
        bus_w = 24'h43_10_99;
        #1;
        chk("R10 cascade out on unequal byte", cso_w[2], 1'b0);

        // R9: low cascade input suppresses GT/LT
        top_si = 1'b0;
        #1;
        chk("R9 gated unequal", {gt_line, lt_line, eq_line}, 3'b110);
        chk("R9 gated cascade out", cso_w[2], 1'b0);
        bus_w = 24'h42_10_99;
        #1;
        chk("R9 gated equal", {gt_line, lt_line, eq_line}, 3'b111);
        top_si = 1'b1;

        // R6 R7 R11: sweep over byte values and word shapes
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int s = 0; s < 4; s++) begin
                    a = {pick(i), pick(i + s), pick(i * 3 + s)};
                    case (s)
                        0: b = {pick(j), a[15:0]};
                        1: b = {a[23:8], pick(j)};
                        2: b = {a[23:16], pick(j), a[7:0]};
                        default: b = {pick(j), pick(j + 1), pick(j + 5)};
                    endcase
                    cmp_check(a, b, 1'b0);
                    cmp_check(a, b, 1'b1);
                end
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule